// File: doc/BRIEF.md
# Reload-on-Carry Serial Clock Divider

This block derives a square-wave serial clock from the system clock. A small up-counter steps once per enabled system clock. When its increment produces a carry out of the top bit, the counter is loaded with the programmed divide value and the output level flips. Because each half-period is the run from the loaded value up to the all-ones state, a divide value `d` gives `2^CNT_W - d` system cycles per half, and the high and low halves are always the same length.

The enable input gates every state change. While it is low, the output level and the count in progress are frozen. Two single-cycle strobes mark the rising and falling transitions of the output. They are high in the same cycle as the new level, so a serial shifter can use them as internal clock events. Phase alignment to transfer starts and the choice of another clock source belong to surrounding logic.

Top module: `clkdiv_reload`

## Requirements
- R1: While the synchronous reset is high at a clock edge, the output level, the rise strobe and the fall strobe are all 0 after that edge.
- R2: After reset is released with enable high, the first transition is a rise. It appears after exactly `2^CNT_W` enabled cycles (32 by default), because the counter starts from zero.
- R3: With divide value `d` in force, every half-period lasts `2^CNT_W - d` enabled cycles, and consecutive high and low halves are equal. The number of enabled cycles between transitions never exceeds `2^CNT_W`.
- R4: A divide value of 0 is legal: the divider keeps running, with halves of `2^CNT_W` cycles.
- R5: The maximum divide value (all ones) makes the output flip on every enabled cycle.
- R6: On a clock edge where enable is low, the output level and the count progress hold, and both strobes are 0 after that edge.
- R7: The rise strobe is high for exactly the one cycle in which the output has just gone from 0 to 1. The fall strobe is high for exactly the one cycle in which it has just gone from 1 to 0. The two strobes are never high together.
- R8: A divide value changed in the middle of a half-period does not shorten that half. It is first used at the next reload, which occurs on the edge of the next transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; all state holds while low |
| div_i | input | CNT_W | Divide value loaded at each reload |
| sclk_o | output | 1 | Divided clock level |
| rise_o | output | 1 | One-cycle strobe in the cycle the level has just risen |
| fall_o | output | 1 | One-cycle strobe in the cycle the level has just fallen |

## Verification
The bench builds the block at the default width of 5 bits. At that width the longest half-period is 32 cycles, so the zero divide value, the all-ones value and several values in between can each be timed over two full halves in a short run. Keeping the real width also exercises the carry out of the top bit at the actual counter size, rather than at a narrowed one. Enable gaps and mid-half divide changes are placed at known offsets inside a half, so the cycle in which each transition is expected can be derived from R3.

// File: rtl/clkdiv_reload_pkg.sv
package clkdiv_reload_pkg;

   // strobe pair marking the two transitions of the divided clock
   typedef struct packed {
      logic rise;
      logic fall;
   } clkdiv_edge_t;

   localparam int unsigned CLKDIV_MIN_W = 2;
   localparam int unsigned CLKDIV_MAX_W = 16;

endpackage

// File: rtl/clkdiv_reload_count.sv
module clkdiv_reload_count #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   input  logic [CNT_W-1:0] load_i,
   output logic             carry_o
);

   localparam int unsigned SUM_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [SUM_W-1:0] sum;

   // widened sum exposes the carry without a stored flag
   assign sum     = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
   assign carry_o = sum[SUM_W-1];

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= '0;
      end else if (en_i) begin
         if (carry_o) cnt_q <= load_i;
         else         cnt_q <= sum[CNT_W-1:0];
      end
   end

endmodule

// File: rtl/clkdiv_reload_phase.sv
module clkdiv_reload_phase
   import clkdiv_reload_pkg::*;
(
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         en_i,
   input  logic         carry_i,
   output logic         lvl_o,
   output clkdiv_edge_t edge_o
);

   logic         lvl_q;
   clkdiv_edge_t edge_q;
   logic         flip;

   assign flip = en_i & carry_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         lvl_q       <= 1'b0;
         edge_q.rise <= 1'b0;
         edge_q.fall <= 1'b0;
      end else begin
         if (flip) lvl_q <= ~lvl_q;
         edge_q.rise <= flip & ~lvl_q;
         edge_q.fall <= flip &  lvl_q;
      end
   end

   assign lvl_o  = lvl_q;
   assign edge_o = edge_q;

endmodule

// File: rtl/clkdiv_reload.sv
module clkdiv_reload
   import clkdiv_reload_pkg::*;
#(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   input  logic [CNT_W-1:0] div_i,
   output logic             sclk_o,
   output logic             rise_o,
   output logic             fall_o
);

   generate
      if (CNT_W < CLKDIV_MIN_W || CNT_W > CLKDIV_MAX_W) begin : g_bad_width
         $error("clkdiv_reload: CNT_W out of supported range");
      end
   endgenerate

   logic         carry;
   clkdiv_edge_t edges;

   clkdiv_reload_count #(.CNT_W(CNT_W)) u_count (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .en_i    (en_i),
      .load_i  (div_i),
      .carry_o (carry)
   );

   clkdiv_reload_phase u_phase (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .en_i    (en_i),
      .carry_i (carry),
      .lvl_o   (sclk_o),
      .edge_o  (edges)
   );

   assign rise_o = edges.rise;
   assign fall_o = edges.fall;

endmodule

// File: rtl/clkdiv_reload_chk.sv
module clkdiv_reload_chk #(
   parameter int unsigned CNT_W = 5
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             en_i,
   input logic [CNT_W-1:0] div_i,
   input logic             sclk_o,
   input logic             rise_o,
   input logic             fall_o
);

   localparam int unsigned LIM = 1 << CNT_W;

   // enabled edges since the last transition became visible
   int unsigned run;

   always_ff @(posedge clk_i) begin
      if (rst_i)                 run <= 0;
      else if (rise_o || fall_o) run <= en_i ? 1 : 0;
      else if (en_i)             run <= run + 1;
   end

   assert_rise_match_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      rise_o == $rose(sclk_o));

   assert_fall_match_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      fall_o == $fell(sclk_o));

   assert_single_rise_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      rise_o |=> !rise_o);

   assert_strobe_excl_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      !(rise_o && fall_o));

   assert_hold_level_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> $stable(sclk_o));

   assert_hold_strobe_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> (!rise_o && !fall_o));

   assert_half_bound_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      run <= LIM);

   // div_i is observed only so the checker sees the full port set
   logic unused_div;
   assign unused_div = ^div_i;

endmodule

bind clkdiv_reload clkdiv_reload_chk #(.CNT_W(CNT_W)) u_clkdiv_reload_chk (
   .clk_i  (clk_i),
   .rst_i  (rst_i),
   .en_i   (en_i),
   .div_i  (div_i),
   .sclk_o (sclk_o),
   .rise_o (rise_o),
   .fall_o (fall_o)
);

// File: tb/test_clkdiv_reload.sv
`timescale 1ns/1ps
module test_clkdiv_reload;

   localparam int unsigned W    = 5;
   localparam int          FULL = 1 << W;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         en  = 1'b0;
   logic [W-1:0] div = '0;
   logic         sclk, rise, fall;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   logic last = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   clkdiv_reload #(.CNT_W(W)) i_clkdiv_reload (
      .clk_i  (clk),
      .rst_i  (rst),
      .en_i   (en),
      .div_i  (div),
      .sclk_o (sclk),
      .rise_o (rise),
      .fall_o (fall)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // count enabled cycles to the next output transition, checking strobes
   task automatic wait_toggle(output int n);
      int stray = 0;
      n = 0;
      do begin
         step();
         n++;
         if (sclk == last && (rise || fall)) stray++;
      end while (sclk == last && n < 200);
      check(stray == 0, "R7 stray strobe", stray, 0);
      check(rise == sclk && fall == !sclk, "R7 strobe at transition",
            {30'd0, rise, fall}, {30'd0, sclk, !sclk});
      last = sclk;
   endtask

   task automatic t_reset();
      int n;
      rst = 1'b1; en = 1'b1; div = '0;
      repeat (3) step();
      check(sclk == 0 && rise == 0 && fall == 0, "R1 reset state",
            {29'd0, sclk, rise, fall}, 0);
      rst  = 1'b0;
      last = 1'b0;
      wait_toggle(n);
      check(n == FULL, "R2 first half after reset", n, FULL);
      check(sclk == 1'b1, "R2 first transition is a rise", sclk, 1);
   endtask

   task automatic t_half(input int d, input string req);
      int n0, n1, n2;
      div = W'(d);
      wait_toggle(n0);         // reload with d happens at this edge
      wait_toggle(n1);
      wait_toggle(n2);
      check(n1 == FULL - d, req, n1, FULL - d);
      check(n2 == n1, {req, " equal halves"}, n2, n1);
   endtask

   task automatic t_enable();
      int n;
      int moved = 0;
      div = W'(24);            // half of 8
      wait_toggle(n);
      wait_toggle(n);
      repeat (3) step();
      en = 1'b0;
      repeat (10) begin
         step();
         if (sclk != last || rise || fall) moved++;
      end
      check(moved == 0, "R6 hold while disabled", moved, 0);
      en = 1'b1;
      wait_toggle(n);
      check(n == 5, "R6 count resumes", n, 5);
   endtask

   task automatic t_change();
      int n;
      div = W'(16);
      wait_toggle(n);
      wait_toggle(n);          // this edge reloaded 16
      div = W'(28);
      wait_toggle(n);
      check(n == 16, "R8 current half keeps old value", n, 16);
      wait_toggle(n);
      check(n == 4, "R8 new value at next reload", n, 4);
   endtask

   initial begin
      t_reset();
      t_half(20, "R3 half period d=20");
      t_half(0,  "R4 zero divide");
      t_half(31, "R5 maximum divide");
      t_half(7,  "R3 half period d=7");
      t_enable();
      t_change();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule